// File: doc/BRIEF.md
# Keyed Watchdog Timer with Stretched Reset Pulse

This block supervises software. It divides the oscillator clock down to a slow tick and counts those ticks in an up counter. Software must keep the count from reaching its top by writing a two-step key into the key register. If software misses its deadline, the block drives a fixed-length active-low pulse. That pulse goes either to the core reset line or to an interrupt line that can also wake the device from a low-power state. The block also fires at once when software writes the control register with a wrong check pattern. A stray write therefore cannot quietly reconfigure the timer. Because every counter runs on the oscillator clock, the count simply freezes if that clock stops.

Software reaches the block through a write-only port with a 2-bit register select. Select 0 is control: bit 7 routes the pulse to the interrupt line, bit 6 halts the timer, bits 5:3 are the check field, and bits 2:0 select the divider. Select 1 is the key register. Select 2 is status, where writing bit 0 as 1 clears the watchdog-reset flag. The current count and the flag are outputs.

The key detector has two states, KEY_WAIT and KEY_ARMED. A write of 0x55 moves it to KEY_ARMED from either state. In KEY_ARMED, a write of 0xAA clears the timer and returns it to KEY_WAIT, and any other key value returns it to KEY_WAIT without clearing. The pulse generator has two states, PUL_IDLE and PUL_ACTIVE. A start request while in PUL_IDLE enters PUL_ACTIVE. The generator leaves PUL_ACTIVE after PULSE_LEN cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the count is 0, both pulse outputs are high, and the flag is 0. The divider select resets to divide-by-1, the halt bit to 0 and the route bit to 0.
- R2: While the timer is running, the count advances by one every FIXED_DIV × ratio oscillator cycles, measured from the last clear. The count is visible on `count_o`.
- R3: Starting from a clear, the tick that would carry the count to its maximum (2^CNT_W − 1) is the expiry. At that edge the count restarts from 0 and the pulse starts, so the output is low in the very next cycle.
- R4: With route bit 7 at 0, an expiry drives `wd_rst_n_o` low for exactly PULSE_LEN cycles, and `wd_int_n_o` stays high.
- R5: With route bit 7 at 1, an expiry drives `wd_int_n_o` low for exactly PULSE_LEN cycles, and `wd_rst_n_o` stays high.
- R6: A key write of 0x55 followed directly by a key write of 0xAA clears both the count and the divider chain. Servicing at least once per period prevents any pulse.
- R7: In KEY_ARMED, any key value other than 0xAA or 0x55 returns the detector to KEY_WAIT without clearing the count, so a later 0xAA has no effect. A repeated 0x55 keeps the detector armed.
- R8: Divider select bits 2:0 set the ratio: 000 and 001 give 1, and a value n from 010 to 111 gives 2^(n−1), which is 2 up to 64.
- R9: While halt bit 6 is 1, the count holds its value and no expiry occurs. A good key still clears the count while halted.
- R10: A control write whose bits 5:3 differ from 101 is discarded. It clears the count and starts a pulse on `wd_rst_n_o`, whatever the route bit says.
- R11: The flag is set when a pulse starts on the reset line. It is cleared by a status write with bit 0 equal to 1. A status write with bit 0 equal to 0 leaves it unchanged, and setting wins over clearing.
- R12: Once a pulse is active it runs its full PULSE_LEN cycles. Any start request during it is ignored and does not lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 key, 2 status |
| wr_data | input | 8 | Write data |
| count_o | output | CNT_W | Current watchdog count |
| wd_flag_o | output | 1 | Last reset came from the watchdog |
| wd_rst_n_o | output | 1 | Active-low core reset pulse |
| wd_int_n_o | output | 1 | Active-low interrupt/wakeup pulse |

## Verification
The bench pins the expiry to an exact cycle after a service. A design that fired on reaching the maximum count, rather than on the tick that carries the count there, would expire one tick late. A design that did not clear the divider on service would drift by up to one divider period. Broken key sequences such as 0x55, 0x12, 0xAA and re-armed ones such as 0x55, 0x55, 0xAA are checked against the count, which catches a detector that ignores the intervening value or drops the re-arm. A bad check write is injected while a pulse is already low. A design that restarted the pulse would show more than PULSE_LEN low cycles, and one that honoured the discarded control value would change the tick rate afterwards.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic {
        KEY_WAIT  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;

    typedef enum logic {
        PUL_IDLE   = 1'b0,
        PUL_ACTIVE = 1'b1
    } pulse_state_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_KEY    = 2'd1,
        SEL_STATUS = 2'd2
    } reg_sel_t;

    typedef struct packed {
        logic       route_int;
        logic       halt;
        logic [2:0] chk;
        logic [2:0] div_sel;
    } ctrl_t;

    localparam logic [2:0] CHK_GOOD  = 3'b101;
    localparam logic [7:0] KEY_FIRST = 8'h55;
    localparam logic [7:0] KEY_LAST  = 8'hAA;

endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int FIXED_DIV = 512,
    parameter int MAX_SHIFT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] div_sel,
    output logic       tick
);
    localparam int FW = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
    localparam logic [FW-1:0] FIX_LAST = FW'(FIXED_DIV - 1);

    logic [FW-1:0]        fix_q;
    logic [MAX_SHIFT-1:0] sel_q;
    logic [MAX_SHIFT-1:0] ratio_m1;
    logic [2:0]           shift;
    logic                 fix_wrap;

    always_comb begin
        shift    = (div_sel < 3'd2) ? 3'd0 : div_sel - 3'd1;
        ratio_m1 = MAX_SHIFT'((32'd1 << shift) - 32'd1);
    end

    assign fix_wrap = (fix_q == FIX_LAST);
    assign tick     = run && fix_wrap && (sel_q >= ratio_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fix_q <= '0;
            sel_q <= '0;
        end else if (clr) begin
            fix_q <= '0;
            sel_q <= '0;
        end else if (run) begin
            if (fix_wrap) begin
                fix_q <= '0;
                sel_q <= (sel_q >= ratio_m1) ? '0 : sel_q + 1'b1;
            end else begin
                fix_q <= fix_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/kwd_keydet.sv
module kwd_keydet
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       good_key
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_WAIT: begin
                if (key_wr && key_val == KEY_FIRST) state_d = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (key_wr) state_d = (key_val == KEY_FIRST) ? KEY_ARMED : KEY_WAIT;
            end
        endcase
    end

    always_comb begin
        good_key = (state_q == KEY_ARMED) && key_wr && (key_val == KEY_LAST);
    end

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse
    import kwd_pkg::*;
#(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic to_int,
    output logic busy,
    output logic rst_line_n,
    output logic int_line_n
);
    localparam int LW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [LW-1:0] LEN_LAST = LW'(LEN - 1);

    pulse_state_t state_q, state_d;
    logic [LW-1:0] len_q;
    logic          route_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PUL_IDLE;
            len_q   <= '0;
            route_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PUL_IDLE) begin
                len_q <= '0;
                if (start) route_q <= to_int;
            end else begin
                len_q <= len_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PUL_IDLE:   if (start) state_d = PUL_ACTIVE;
            PUL_ACTIVE: if (len_q == LEN_LAST) state_d = PUL_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q == PUL_ACTIVE);
        rst_line_n = !(busy && !route_q);
        int_line_n = !(busy && route_q);
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int FIXED_DIV = 512,
    parameter int PULSE_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             wd_flag_o,
    output logic             wd_rst_n_o,
    output logic             wd_int_n_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam ctrl_t CTRL_RST = '{route_int: 1'b0, halt: 1'b0,
                                   chk: CHK_GOOD, div_sel: 3'b001};

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             ctrl_wr, key_wr, stat_wr, bad_chk;
    logic             tick, good_key, expire, clr;
    logic             pulse_start, pulse_to_int, pulse_busy;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign key_wr  = wr_en && (wr_sel == SEL_KEY);
    assign stat_wr = wr_en && (wr_sel == SEL_STATUS);
    assign bad_chk = ctrl_wr && (wr_data[5:3] != CHK_GOOD);

    assign expire       = tick && (cnt_q == CNT_LAST);
    assign clr          = good_key || expire || bad_chk;
    assign pulse_start  = expire || bad_chk;
    assign pulse_to_int = bad_chk ? 1'b0 : ctrl_q.route_int;

    kwd_prescaler #(
        .FIXED_DIV (FIXED_DIV),
        .MAX_SHIFT (6)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (!ctrl_q.halt),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    kwd_keydet u_keydet (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (wr_data),
        .good_key (good_key)
    );

    kwd_pulse #(
        .LEN (PULSE_LEN)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (pulse_start),
        .to_int     (pulse_to_int),
        .busy       (pulse_busy),
        .rst_line_n (wd_rst_n_o),
        .int_line_n (wd_int_n_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ctrl_q <= CTRL_RST;
        else if (ctrl_wr && !bad_chk) ctrl_q <= ctrl_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    flag_q <= 1'b0;
        else if (pulse_start && !pulse_busy && !pulse_to_int) flag_q <= 1'b1;
        else if (stat_wr && wr_data[0])                flag_q <= 1'b0;
    end

    assign count_o   = cnt_q;
    assign wd_flag_o = flag_q;

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [7:0]       wr_data,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             rst_line_n,
    input logic             int_line_n,
    input logic             halt,
    input logic             good_key
);
    logic        line_ok;
    logic        bad_wr;
    int unsigned low_run;

    assign line_ok = rst_line_n && int_line_n;
    assign bad_wr  = wr_en && (wr_sel == 2'd0) && (wr_data[5:3] != 3'b101);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run <= 0;
        else if (!line_ok) low_run <= low_run + 1;
        else               low_run <= 0;
    end

    // R4 R5: never both lines low at once
    a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rst_line_n && !int_line_n));

    // R4 R12: a pulse ends exactly after PULSE_LEN low cycles
    a_r12_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_ok) |-> (low_run == PULSE_LEN));

    a_r12_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= PULSE_LEN);

    // R10: bad check from idle gives a reset pulse and a cleared count
    a_r10_bad_check: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && line_ok) |=> (!rst_line_n && count == '0));

    // R6: good key clears the count
    a_r6_good_clear: assert property (@(posedge clk) disable iff (!rst_n)
        good_key |=> (count == '0));

    // R9: halted timer holds its count
    a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !good_key && !bad_wr) |=> $stable(count));

    // R11: a reset-line pulse always comes with the flag set
    a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_line_n) |-> flag);

endmodule

bind keyed_watchdog kwd_checker #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
) u_kwd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .count      (count_o),
    .flag       (wd_flag_o),
    .rst_line_n (wd_rst_n_o),
    .int_line_n (wd_int_n_o),
    .halt       (ctrl_q.halt),
    .good_key   (good_key)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    localparam int CNT_W     = 4;
    localparam int FIXED_DIV = 4;
    localparam int PULSE_LEN = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [1:0]       wr_sel;
    logic [7:0]       wr_data;
    logic [CNT_W-1:0] count_o;
    logic             wd_flag_o, wd_rst_n_o, wd_int_n_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(
        .CNT_W     (CNT_W),
        .FIXED_DIV (FIXED_DIV),
        .PULSE_LEN (PULSE_LEN)
    ) i_keyed_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .count_o    (count_o),
        .wd_flag_o  (wd_flag_o),
        .wd_rst_n_o (wd_rst_n_o),
        .wd_int_n_o (wd_int_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
    endtask

    task automatic service();
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 count", int'(count_o), 0);
        check("R1 rst line", int'(wd_rst_n_o), 1);
        check("R1 int line", int'(wd_int_n_o), 1);
        check("R1 flag", int'(wd_flag_o), 0);
    endtask

    task automatic t_expiry_reset_route();
        int lows;
        int int_lows;
        service();
        wait_n(59);
        check("R3 line before expiry", int'(wd_rst_n_o), 1);
        check("R3 count before expiry", int'(count_o), 14);
        wait_n(1);
        check("R3 line at expiry", int'(wd_rst_n_o), 0);
        check("R3 count restart", int'(count_o), 0);
        check("R11 flag set", int'(wd_flag_o), 1);
        lows = 1; int_lows = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!wd_rst_n_o) lows++;
            if (!wd_int_n_o) int_lows++;
        end
        check("R4 reset width", lows, PULSE_LEN);
        check("R4 int quiet", int_lows, 0);
        service();
    endtask

    task automatic t_flag_clear();
        wr(2'd2, 8'h00);
        check("R11 flag kept", int'(wd_flag_o), 1);
        wr(2'd2, 8'h01);
        check("R11 flag cleared", int'(wd_flag_o), 0);
        service();
    endtask

    task automatic t_service_alive();
        int lows = 0;
        service();
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!wd_rst_n_o) lows++;
            end
            check("R2 count after 40", int'(count_o), 10);
            service();
        end
        check("R6 no pulse while serviced", lows, 0);
    endtask

    task automatic t_key_order();
        service();
        wait_n(20);
        check("R2 count at 20", int'(count_o), 5);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'h12);
        wr(2'd1, 8'hAA);
        check("R7 broken key no clear", int'(count_o), 5);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
        check("R7 rearm clears", int'(count_o), 0);
    endtask

    task automatic t_prescaler();
        wr(2'd0, 8'h2B);
        service();
        wait_n(32);
        check("R8 div4 at 32", int'(count_o), 2);
        wait_n(16);
        check("R8 div4 at 48", int'(count_o), 3);
        wr(2'd0, 8'h28);
        service();
        wait_n(8);
        check("R8 sel000 div1", int'(count_o), 2);
        wr(2'd0, 8'h2F);
        service();
        wait_n(255);
        check("R8 div64 before step", int'(count_o), 0);
        wait_n(1);
        check("R8 div64 step", int'(count_o), 1);
        wr(2'd0, 8'h29);
        service();
    endtask

    task automatic t_halt();
        int lows = 0;
        service();
        wait_n(10);
        check("R2 count at 10", int'(count_o), 2);
        wr(2'd0, 8'h69);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!wd_rst_n_o) lows++;
        end
        check("R9 halted count held", int'(count_o), 2);
        service();
        check("R9 key clears while halted", int'(count_o), 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!wd_rst_n_o) lows++;
        end
        check("R9 halted count zero", int'(count_o), 0);
        check("R9 no pulse halted", lows, 0);
        wr(2'd0, 8'h29);
        service();
    endtask

    task automatic t_int_route();
        int lows;
        int rst_lows;
        wr(2'd0, 8'hA9);
        service();
        wait_n(59);
        check("R5 int before expiry", int'(wd_int_n_o), 1);
        wait_n(1);
        check("R5 int at expiry", int'(wd_int_n_o), 0);
        lows = 1;
        rst_lows = wd_rst_n_o ? 0 : 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!wd_int_n_o) lows++;
            if (!wd_rst_n_o) rst_lows++;
        end
        check("R5 int width", lows, PULSE_LEN);
        check("R5 reset quiet", rst_lows, 0);
        check("R11 flag not set by int", int'(wd_flag_o), 0);
        service();
        wr(2'd0, 8'h29);
    endtask

    task automatic t_bad_check();
        int lows;
        int int_lows = 0;
        wr(2'd0, 8'hAB);
        service();
        wait_n(20);
        check("R2 count before bad write", int'(count_o), 1);
        wr(2'd0, 8'h00);
        check("R10 reset line low", int'(wd_rst_n_o), 0);
        check("R10 count cleared", int'(count_o), 0);
        check("R11 flag on bad check", int'(wd_flag_o), 1);
        lows = 1;
        for (int i = 0; i < 25; i++) begin
            if (i == 4) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h03; end
            if (i == 5) begin wr_en = 1'b0; wr_data = 8'h00; end
            @(negedge clk);
            if (!wd_rst_n_o) lows++;
            if (!wd_int_n_o) int_lows++;
        end
        check("R12 no restart during pulse", lows, PULSE_LEN);
        check("R10 int quiet", int_lows, 0);
        service();
        wait_n(32);
        check("R10 control write discarded", int'(count_o), 2);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h29);
        service();
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
        wait_n(3);
        rst_n = 1'b1;
        t_reset();
        t_expiry_reset_route();
        t_flag_clear();
        t_service_alive();
        t_key_order();
        t_prescaler();
        t_halt();
        t_int_route();
        t_bad_check();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule